// File: doc/BRIEF.md
# Two-Stage RC Oscillator Trim Calibrator

This block searches for a 10-bit trim word for an on-chip RC oscillator. The word is split into a 5-bit coarse field in bits [9:5] and a 5-bit fine field in bits [4:0]. For every trial word the block drives the trim output and lets it settle for a fixed number of cycles. It then pulses a request to an external period counter and waits for the counter to return a 16-bit period count.

The search has two stages. In each stage the block measures the two ends of the field and makes a first guess by truncated linear interpolation toward the target period. It then walks the guess one code at a time. The coarse stage walks down until the period is no shorter than the target. The fine stage walks in either direction until the period is no longer than the target and lies inside the allowed period window. A walk that would leave the field range stops the run with a failure. A fine walk that keeps alternating between two codes also stops the run with a failure.

Top module: `rc_trim_cal`

## Requirements
- R1: After reset, trim is 0 and done, fail and meas_req are 0. A run starts by measuring trim 0 (coarse 0, fine 0) and then trim 992 (coarse 31, fine 0).
- R2: Every measurement made during the coarse stage has the fine field, trim[4:0], at 0.
- R3: meas_req is a one-cycle pulse. It is issued only after trim has held its value for at least SETTLE (default 4) cycles. meas_valid is ignored unless the block is waiting for a measurement.
- R4: Each estimate is floor(31*(Pa-T)/(Pa-Pb)) clamped to 31. Pa is the period at field 0, Pb is the period at field 31, and T is tgt_period. The estimate is 0 when Pa <= T, and 31 when Pb >= Pa while Pa > T.
- R5: At the coarse estimate, a period of at least tgt_period accepts the coarse value. A shorter period decrements coarse by 1 and measures again.
- R6: The fine stage reuses the accepted coarse measurement as its fine-0 endpoint. It measures fine 31 at the accepted coarse value, then measures the fine estimate.
- R7: In the fine stage, a period below lim_lo_period decrements fine. Otherwise a period above tgt_period or above lim_hi_period increments fine. Otherwise the word is accepted.
- R8: If a step would take a field below 0 or above 31, fail rises and trim keeps the last measured word. Both stay until the next start.
- R9: If the fine walk reverses direction on two consecutive steps, fail rises and trim keeps the last measured word.
- R10: On acceptance, done is high for exactly one cycle and trim holds the final word. fail clears when a new run starts. A start pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse; begins a run when idle |
| tgt_period | input | 16 | Target period count |
| lim_lo_period | input | 16 | Shortest allowed period (upper frequency limit) |
| lim_hi_period | input | 16 | Longest allowed period (lower frequency limit) |
| meas_valid | input | 1 | Period count on meas_period is valid |
| meas_period | input | 16 | Measured oscillator period count |
| trim | output | 10 | Trim word: coarse [9:5], fine [4:0] |
| meas_req | output | 1 | One-cycle measurement request |
| done | output | 1 | One-cycle pulse on acceptance |
| fail | output | 1 | Search failed; held until next start |

## Verification
A trim change appears one cycle after the block sees a measurement response. meas_req follows SETTLE cycles after that change, and an estimate becomes a trim word about 22 cycles after the second endpoint response. The bench answers each request from an oscillator model a fixed two cycles later. It samples every output 1 ns after the clock edge and counts how many cycles trim has been stable when each request arrives. It does not predict absolute cycle numbers. It logs the sequence of measured trim words and checks that sequence against hand-computed interpolation and walk results. It checks done and fail at each sampled cycle, and it checks that done is high for one cycle only.

// File: rtl/trim_cal_pkg.sv
// Shared types for the trim calibrator.
// Assumes: nothing beyond 1800-2017 enum support.
package trim_cal_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_MEAS, ST_DIV} cal_state_t;

    typedef enum logic [2:0] {
        SP_C_LO, SP_C_HI, SP_C_EST, SP_F_HI, SP_F_EST
    } cal_step_t;

    typedef enum logic [1:0] {DIR_NONE, DIR_UP, DIR_DN} walk_dir_t;

    typedef enum logic [1:0] {MP_IDLE, MP_SETTLE, MP_WAIT} meas_phase_t;

endpackage

// File: rtl/trim_meas_port.sv
// Measurement handshake: waits SETTLE cycles after go, pulses req for one
// cycle, then captures the first valid period count and pulses rdy.
// Assumes: go is a one-cycle pulse issued in the cycle after trim changed;
// valid outside the wait phase is dropped.
module trim_meas_port
    import trim_cal_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             meas_valid,
    input  logic [PER_W-1:0] meas_period,
    output logic             meas_req,
    output logic [PER_W-1:0] per,
    output logic             rdy
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    meas_phase_t      phase;
    logic [CNT_W-1:0] cnt;

    // Settle countdown, request pulse and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= MP_IDLE;
            cnt      <= '0;
            meas_req <= 1'b0;
            per      <= '0;
            rdy      <= 1'b0;
        end else begin
            meas_req <= 1'b0;
            rdy      <= 1'b0;
            if (go) begin
                phase <= MP_SETTLE;
                cnt   <= CNT_W'(SETTLE);
            end else begin
                case (phase)
                    MP_SETTLE: begin
                        if (cnt <= CNT_W'(1)) begin
                            meas_req <= 1'b1;
                            phase    <= MP_WAIT;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    MP_WAIT: begin
                        if (meas_valid) begin
                            per   <= meas_period;
                            rdy   <= 1'b1;
                            phase <= MP_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trim_interp.sv
// Interpolated field estimate: floor(FMAX*(tmax-tgt)/(tmax-tmin)), clamped
// to FMAX. A bit-serial restoring divider makes one quotient bit per cycle.
// Assumes: start is a one-cycle pulse and is not raised while busy.
module trim_interp #(
    parameter int PER_W   = 16,
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PER_W-1:0]   tmax,
    input  logic [PER_W-1:0]   tmin,
    input  logic [PER_W-1:0]   tgt,
    output logic [FIELD_W-1:0] code,
    output logic               done
);
    localparam int NW    = PER_W + FIELD_W;
    localparam int FMAX  = (1 << FIELD_W) - 1;
    localparam int CNT_W = $clog2(NW + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] rem, dvs;
    logic [NW-1:0]    quo;
    logic [PER_W:0]   trial;
    logic             ge;
    logic [PER_W-1:0] rem_nxt;
    logic [NW-1:0]    quo_nxt;
    logic [NW-1:0]    num_ext;

    // One restoring step: shift in the next dividend bit and try a subtract.
    always_comb begin
        trial   = {rem, quo[NW-1]};
        ge      = (trial >= {1'b0, dvs});
        rem_nxt = ge ? PER_W'(trial - {1'b0, dvs}) : trial[PER_W-1:0];
        quo_nxt = {quo[NW-2:0], ge};
        num_ext = {{FIELD_W{1'b0}}, PER_W'(tmax - tgt)};
    end

    // Load the operands or handle the degenerate cases, then iterate NW times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            dvs  <= '0;
            quo  <= '0;
            code <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (tmax <= tgt) begin
                    code <= '0;
                    done <= 1'b1;
                end else if (tmax <= tmin) begin
                    code <= FIELD_W'(FMAX);
                    done <= 1'b1;
                end else begin
                    rem  <= '0;
                    quo  <= num_ext * NW'(FMAX);
                    dvs  <= tmax - tmin;
                    cnt  <= CNT_W'(NW);
                    busy <= 1'b1;
                end
            end else if (busy) begin
                rem <= rem_nxt;
                quo <= quo_nxt;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    code <= (quo_nxt > NW'(FMAX)) ? FIELD_W'(FMAX)
                                                  : quo_nxt[FIELD_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/rc_trim_cal.sv
// Two-stage trim search controller: coarse then fine, each stage built from
// an interpolated guess and a single-step walk.
// Assumes: inputs tgt/lim stay constant during a run; the period counter
// answers every request.
module rc_trim_cal
    import trim_cal_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int PER_W   = 16,
    parameter int SETTLE  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PER_W-1:0]     tgt_period,
    input  logic [PER_W-1:0]     lim_lo_period,
    input  logic [PER_W-1:0]     lim_hi_period,
    input  logic                 meas_valid,
    input  logic [PER_W-1:0]     meas_period,
    output logic [2*FIELD_W-1:0] trim,
    output logic                 meas_req,
    output logic                 done,
    output logic                 fail
);
    localparam int FMAX = (1 << FIELD_W) - 1;

    cal_state_t         st;
    cal_step_t          step;
    walk_dir_t          last_dir, new_dir;
    logic               rev_once, reversal, at_edge, want_dn, want_up;
    logic [FIELD_W-1:0] crs, fin, est;
    logic [PER_W-1:0]   t_hi, t_lo, meas_per;
    logic               go, rdy, div_go, div_done, coarse_phase;

    assign trim         = {crs, fin};
    assign coarse_phase = (step == SP_C_LO) || (step == SP_C_HI) || (step == SP_C_EST);

    trim_meas_port #(.PER_W(PER_W), .SETTLE(SETTLE)) u_meas (
        .clk(clk), .rst_n(rst_n), .go(go),
        .meas_valid(meas_valid), .meas_period(meas_period),
        .meas_req(meas_req), .per(meas_per), .rdy(rdy)
    );

    trim_interp #(.PER_W(PER_W), .FIELD_W(FIELD_W)) u_interp (
        .clk(clk), .rst_n(rst_n), .start(div_go),
        .tmax(t_hi), .tmin(t_lo), .tgt(tgt_period),
        .code(est), .done(div_done)
    );

    // Fine-walk decision: direction, range check and reversal tracking.
    always_comb begin
        want_dn  = (meas_per < lim_lo_period);
        want_up  = !want_dn && ((meas_per > tgt_period) || (meas_per > lim_hi_period));
        new_dir  = want_dn ? DIR_DN : (want_up ? DIR_UP : DIR_NONE);
        at_edge  = (want_dn && (fin == '0)) || (want_up && (fin == FIELD_W'(FMAX)));
        reversal = (last_dir != DIR_NONE) && (new_dir != last_dir);
    end

    // Search sequencer: endpoint measurements, estimates and walks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            step     <= SP_C_LO;
            crs      <= '0;
            fin      <= '0;
            t_hi     <= '0;
            t_lo     <= '0;
            go       <= 1'b0;
            div_go   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            last_dir <= DIR_NONE;
            rev_once <= 1'b0;
        end else begin
            go     <= 1'b0;
            div_go <= 1'b0;
            done   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        fail     <= 1'b0;
                        crs      <= '0;
                        fin      <= '0;
                        step     <= SP_C_LO;
                        last_dir <= DIR_NONE;
                        rev_once <= 1'b0;
                        go       <= 1'b1;
                        st       <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (rdy) begin
                        case (step)
                            SP_C_LO: begin
                                t_hi <= meas_per;
                                crs  <= FIELD_W'(FMAX);
                                step <= SP_C_HI;
                                go   <= 1'b1;
                            end
                            SP_C_HI, SP_F_HI: begin
                                t_lo   <= meas_per;
                                div_go <= 1'b1;
                                st     <= ST_DIV;
                            end
                            SP_C_EST: begin
                                if (meas_per >= tgt_period) begin
                                    t_hi <= meas_per;
                                    fin  <= FIELD_W'(FMAX);
                                    step <= SP_F_HI;
                                    go   <= 1'b1;
                                end else if (crs == '0) begin
                                    fail <= 1'b1;
                                    st   <= ST_IDLE;
                                end else begin
                                    crs <= crs - FIELD_W'(1);
                                    go  <= 1'b1;
                                end
                            end
                            default: begin
                                if (new_dir == DIR_NONE) begin
                                    done <= 1'b1;
                                    st   <= ST_IDLE;
                                end else if (at_edge || (reversal && rev_once)) begin
                                    fail <= 1'b1;
                                    st   <= ST_IDLE;
                                end else begin
                                    fin      <= (new_dir == DIR_UP) ? fin + FIELD_W'(1)
                                                                    : fin - FIELD_W'(1);
                                    last_dir <= new_dir;
                                    rev_once <= reversal;
                                    go       <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        if (step == SP_C_HI) begin
                            crs  <= est;
                            step <= SP_C_EST;
                        end else begin
                            fin  <= est;
                            step <= SP_F_EST;
                        end
                        go <= 1'b1;
                        st <= ST_MEAS;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trim_cal_chk.sv
// Property checker for rc_trim_cal, attached by bind.
// Assumes: coarse_phase is the controller's coarse-stage indicator.
module trim_cal_chk #(
    parameter int FIELD_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [2*FIELD_W-1:0] trim,
    input logic                 meas_req,
    input logic                 done,
    input logic                 fail,
    input logic                 coarse_phase
);
    // R3: request is a single-cycle pulse.
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |=> !meas_req);

    // R3: trim does not move in the cycle a request is raised.
    assert_req_trim_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |-> $stable(trim));

    // R2: coarse-stage measurements have the fine field at zero.
    assert_coarse_fine_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && coarse_phase) |-> (trim[FIELD_W-1:0] == '0));

    // R10: done lasts one cycle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done and fail are exclusive.
    assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8: fail and the held word persist until a new start.
    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(trim)));
endmodule

bind rc_trim_cal trim_cal_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .trim(trim),
    .meas_req(meas_req), .done(done), .fail(fail),
    .coarse_phase(coarse_phase)
);

// File: tb/rc_trim_cal_test.sv
`timescale 1ns/1ps
// Directed bench for rc_trim_cal with a piecewise-linear oscillator model.
module rc_trim_cal_test;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tgt_period = '0, lim_lo_period = '0, lim_hi_period = '0;
    logic        resp_valid = 1'b0, spur_valid = 1'b0;
    logic [15:0] meas_period = '0;
    logic        meas_valid;
    logic [9:0]  trim;
    logic        meas_req, done, fail;

    assign meas_valid = resp_valid | spur_valid;

    rc_trim_cal #(.SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_period(tgt_period), .lim_lo_period(lim_lo_period),
        .lim_hi_period(lim_hi_period), .meas_valid(meas_valid),
        .meas_period(meas_period), .trim(trim), .meas_req(meas_req),
        .done(done), .fail(fail)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int m_base = 2000, m_cstep = 40, m_fstep = 3, m_knee = 31, m_extra = 0;
    int mlog[32];
    int mcount = 0;
    int settle_bad = 0;
    int stable_cnt = 0;
    logic [9:0] prev_trim = '0;

    function automatic int model(input logic [9:0] t);
        int c, f, p;
        c = int'(t[9:5]);
        f = int'(t[4:0]);
        p = m_base - c * m_cstep - f * m_fstep;
        if (c > m_knee) p = p + (c - m_knee) * m_extra;
        return p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: stable-cycle count of trim and log of measured words.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (trim != prev_trim) stable_cnt = 0;
            else stable_cnt++;
            prev_trim = trim;
            if (meas_req) begin
                if (mcount < 32) mlog[mcount] = int'(trim);
                mcount++;
                if (stable_cnt < SETTLE) settle_bad++;
            end
        end
    end

    // Period counter model: answers each request two cycles later.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (meas_req) begin
                @(posedge clk); #1;
                meas_period = 16'(model(trim));
                resp_valid  = 1'b1;
                @(posedge clk); #1;
                resp_valid  = 1'b0;
            end
        end
    end

    task automatic run_cal(input int tgt, input int lo, input int hi,
                           input bit extra_start,
                           output int n_done, output bit failed,
                           output bit fail_cleared);
        tgt_period    = 16'(tgt);
        lim_lo_period = 16'(lo);
        lim_hi_period = 16'(hi);
        mcount = 0; settle_bad = 0; n_done = 0; failed = 1'b0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        fail_cleared = !fail;
        for (int i = 0; i < 5000; i++) begin
            if (extra_start && (i == 20 || i == 60)) start = 1'b1;
            else start = 1'b0;
            @(posedge clk); #1;
            if (done) n_done++;
            if (fail) begin failed = 1'b1; break; end
            if (n_done > 0) break;
        end
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (done) n_done++;
        end
    endtask

    task automatic t_reset();
        check("R1 reset trim", int'(trim), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset fail", int'(fail), 0);
        check("R1 reset meas_req", int'(meas_req), 0);
    endtask

    task automatic t_basic();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 31; m_extra = 0;
        run_cal(1000, 980, 1010, 1'b0, nd, fl, fc);
        check("R1 first word", mlog[0], 0);
        check("R1 second word", mlog[1], 992);
        check("R4 coarse estimate", mlog[2], 800);
        check("R6 fine endpoint word", mlog[3], 831);
        check("R7 accept fine 0", int'(trim), 800);
        check("R6 measurement count", mcount, 5);
        check("R10 one done pulse", nd, 1);
        check("R3 settle before request", settle_bad, 0);
    endtask

    task automatic t_fine_step();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 31; m_extra = 0;
        run_cal(990, 980, 1010, 1'b0, nd, fl, fc);
        check("R4 fine estimate 3", mlog[4], 803);
        check("R7 step up to 4", int'(trim), 804);
        check("R7 count", mcount, 6);
        check("R10 done", nd, 1);
    endtask

    task automatic t_coarse_walk();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 10; m_extra = 20;
        run_cal(1300, 1290, 1310, 1'b0, nd, fl, fc);
        check("R4 coarse estimate 26", mlog[2], 832);
        check("R5 coarse decremented", mlog[3], 800);
        check("R2 coarse words fine 0", mlog[2] % 32 + mlog[3] % 32, 0);
        check("R5 final", int'(trim), 800);
        check("R5 done", nd, 1);
    endtask

    task automatic t_clamp_edge();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 10; m_extra = 20;
        run_cal(1000, 980, 1010, 1'b0, nd, fl, fc);
        check("R4 clamp coarse 31", mlog[2], 992);
        check("R8 fail at fine 31", int'(fl), 1);
        check("R8 held word", int'(trim), 1023);
        check("R8 no done", nd, 0);
        for (int i = 0; i < 5; i++) @(posedge clk);
        #1 check("R8 fail held", int'(fail), 1);
    endtask

    task automatic t_negative();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 31; m_extra = 0;
        run_cal(2100, 2000, 2200, 1'b0, nd, fl, fc);
        check("R10 fail cleared on start", int'(fc), 1);
        check("R4 negative numerator gives 0", mlog[2], 0);
        check("R8 fail below coarse 0", int'(fl), 1);
        check("R8 held word 0", int'(trim), 0);
    endtask

    task automatic t_oscillate();
        int nd; bit fl, fc;
        m_base = 2000; m_cstep = 40; m_fstep = 10; m_knee = 31; m_extra = 0;
        run_cal(990, 995, 1010, 1'b0, nd, fl, fc);
        check("R9 walk 801", mlog[4], 801);
        check("R9 walk 800", mlog[5], 800);
        check("R9 walk 801 again", mlog[6], 801);
        check("R9 fail on second reversal", int'(fl), 1);
        check("R9 held word", int'(trim), 801);
        check("R9 measurement count", mcount, 7);
    endtask

    task automatic t_ignore();
        int nd; bit fl, fc;
        // spurious valid while idle: nothing may change
        @(posedge clk); #1 spur_valid = 1'b1; meas_period = 16'd5;
        @(posedge clk); #1 spur_valid = 1'b0;
        for (int i = 0; i < 3; i++) @(posedge clk);
        #1;
        check("R3 idle valid ignored trim", int'(trim), 801);
        check("R3 idle valid no done", int'(done), 0);
        check("R3 idle valid no request", int'(meas_req), 0);
        m_base = 2000; m_cstep = 40; m_fstep = 3; m_knee = 31; m_extra = 0;
        run_cal(990, 980, 1010, 1'b1, nd, fl, fc);
        check("R10 start during run ignored", int'(trim), 804);
        check("R10 count unchanged", mcount, 6);
        check("R10 single done", nd, 1);
        check("R3 settle", settle_bad, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_fine_step();
        t_coarse_walk();
        t_clamp_edge();
        t_negative();
        t_oscillate();
        t_ignore();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule